// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is the synchronous front end of a pipelined burst memory with a 36-bit word split into four 9-bit byte lanes (lane a is bits 8:0, lane b 17:9, lane c 26:18, lane d 35:27). Each rising clock edge samples the address, three chip enables, two address strobes, a burst advance input, the write controls and the write data. An access starts either from the processor-side strobe or from the controller-side strobe. A two-bit burst counter then walks the lowest address bits through four beats, in interleaved or linear order, and can also hold on the current beat.

Writes are decoded per lane into a behavioural array whose depth is set by a parameter. Reads pass through an address stage and an output register, so read data reaches the bus one clock after the address is taken. Output enable gates the bus without a clock. The bus is released during writes and after deselect cycles. The bus is modelled as a data output plus a drive-enable output.

Top module: `burst_sram_ctrl`

## Requirements
- R1: The lane write mask is 4'hF when `all_we_n` is 0. Otherwise it is `~byte_we_n` when `byte_gate_n` is 0, with bit 0 for lane a up to bit 3 for lane d. When `byte_gate_n` is 1 the mask is 0. A zero mask makes the cycle a read, and lanes outside the mask keep their stored value.
- R2: When `burst_mode` is 1, beat k of a burst uses low address bits (start XOR k), and the upper bits stay those of the start address.
- R3: When `burst_mode` is 0, beat k uses low address bits (start + k) mod 4, and the upper bits stay those of the start address.
- R4: When `cs_n` is 1, `strobe_proc_n` has no effect. A low `strobe_ctl_n` is then a deselect, and a high `strobe_ctl_n` continues or suspends the current burst.
- R5: When `cs_n` is 0 but `cs_hi` is 0 or `cs_lo_n` is 1, a low level on either strobe is a deselect. A deselect performs no access and writes nothing, and continue cycles after it do nothing until a new burst starts.
- R6: When the chip is selected and `strobe_proc_n` is low, a read burst starts at `addr` and the write controls are ignored. A write on the next cycle, with both strobes high and `adv_n` high, stores to that same address.
- R7: When the chip is selected, `strobe_proc_n` is high and `strobe_ctl_n` is low, a burst starts at `addr` and is a read or a write according to R1.
- R8: When both strobes are high during a live burst, `adv_n` low moves to the next beat and `adv_n` high repeats the current address. Either kind of cycle reads or writes according to R1.
- R9: A read whose address is taken at edge k drives its data on `rdata` with `rdata_drive` high from edge k+1 until the next edge, as long as `oe_n` is low.
- R10: `oe_n` acts without a clock. `rdata_drive` is 0 after reset, after an edge that performed a write, and one edge after a deselect or an idle cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address |
| cs_n | input | 1 | Primary chip enable, active low, gates the processor strobe |
| cs_hi | input | 1 | Depth-expansion enable, active high |
| cs_lo_n | input | 1 | Depth-expansion enable, active low |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_we_n | input | 1 | Write all lanes, active low |
| byte_gate_n | input | 1 | Enables per-lane writes, active low |
| byte_we_n | input | 4 | Per-lane write enables, active low, bit 0 = lane a |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Output register contents |
| rdata_drive | output | 1 | High when the block drives `rdata` onto the bus |

## Verification
A write lands in the array at the edge that samples it. Its effect on the bus, a released `rdata_drive`, is checked just after that same edge. A read sampled at edge k is due just after edge k+1, and so are the released bus after a deselect or an idle continue. For each cycle it drives, the bench records the edge number at which the result becomes due. A monitor compares that result shortly after the falling edge that follows the due edge. When a write follows a read, the write's expectation replaces the read's expectation, because both are due at the same edge. The asynchronous output enable is checked between edges, apart from the queue.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    // Kind of cycle decoded from enables and strobes at a clock edge.
    typedef enum logic [2:0] {
        OP_DESEL,
        OP_BEGIN_P,
        OP_BEGIN_C,
        OP_NEXT,
        OP_HOLD
    } op_e;

    // Lanes written this cycle; an all-zero mask means a read.
    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_n,
        input logic             gate_n,
        input logic [LANES-1:0] be_n
    );
        if (!all_n)
            return '1;
        else if (!gate_n)
            return ~be_n;
        else
            return '0;
    endfunction

    // Low two address bits for a beat in the chosen burst order.
    function automatic logic [1:0] beat_bits(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             cs_n,
    input  logic             cs_hi,
    input  logic             cs_lo_n,
    input  logic             sp_n,
    input  logic             sc_n,
    input  logic             adv_n,
    input  logic             all_n,
    input  logic             gate_n,
    input  logic [LANES-1:0] be_n,
    input  logic             interleave,
    output logic [AW-1:0]    acc_addr,
    output logic [LANES-1:0] acc_wmask,
    output logic             acc_go,
    output logic             acc_rd
);

    op_e           kind;
    logic          selected;
    logic          starting;
    logic          live_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [AW-1:0] base_use;
    logic [1:0]    cnt_use;

    assign selected = !cs_n && cs_hi && !cs_lo_n;

    // The processor strobe counts only while the primary enable is low.
    always_comb begin
        if (!cs_n && !sp_n)
            kind = selected ? OP_BEGIN_P : OP_DESEL;
        else if (!sc_n)
            kind = selected ? OP_BEGIN_C : OP_DESEL;
        else if (!adv_n)
            kind = OP_NEXT;
        else
            kind = OP_HOLD;
    end

    always_comb begin
        starting = (kind == OP_BEGIN_P) || (kind == OP_BEGIN_C);
        base_use = starting ? addr : base_q;
        if (starting)
            cnt_use = 2'd0;
        else if (kind == OP_NEXT)
            cnt_use = cnt_q + 2'd1;
        else
            cnt_use = cnt_q;
        acc_go    = starting || (((kind == OP_NEXT) || (kind == OP_HOLD)) && live_q);
        acc_addr  = {base_use[AW-1:2], beat_bits(base_use[1:0], cnt_use, interleave)};
        acc_wmask = (acc_go && (kind != OP_BEGIN_P)) ? lane_mask(all_n, gate_n, be_n) : '0;
        acc_rd    = acc_go && (acc_wmask == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            base_q <= '0;
            cnt_q  <= 2'd0;
        end else begin
            if (starting)
                live_q <= 1'b1;
            else if (kind == OP_DESEL)
                live_q <= 1'b0;
            if (acc_go) begin
                base_q <= base_use;
                cnt_q  <= cnt_use;
            end
        end
    end

    // After a deselect, a continue cycle must not reach the array.
    assert_desel_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (kind == OP_DESEL) |=> (!((kind == OP_NEXT) || (kind == OP_HOLD)) || !acc_go));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_go && kind == OP_NEXT && !interleave && $past(acc_go) && !$past(interleave))
        |-> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1
             && acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

    assert_interleave_step_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_go && kind == OP_NEXT && interleave && $past(acc_go) && $past(interleave))
        |-> (acc_addr[0] != $past(acc_addr[0])
             && acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

    assert_hold_same_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_go && kind == OP_HOLD && $past(acc_go) && $stable(interleave))
        |-> (acc_addr == $past(acc_addr)));

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     acc_addr,
    input  logic [LANES-1:0]  acc_wmask,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rd_vld_q
);

    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] rd_addr_q;
    logic          rd_pend_q;

    // Address stage, then output register: read data lands one edge later.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q <= 1'b0;
            rd_vld_q  <= 1'b0;
        end else begin
            rd_pend_q <= acc_rd;
            rd_vld_q  <= rd_pend_q;
        end
    end

    always_ff @(posedge clk) begin
        rd_addr_q <= acc_addr;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (acc_wmask[g])
                store[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_pend_q)
                out_q <= store[rd_addr_q];
        end

        assign rdata_q[g*LANE_W +: LANE_W] = out_q;
    end

endmodule

// File: rtl/bsram_drive.sv
module bsram_drive (
    input  logic clk,
    input  logic rst,
    input  logic wr_now,
    input  logic rd_vld,
    input  logic oe_n,
    output logic rdata_drive
);

    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst)
            wr_q <= 1'b0;
        else
            wr_q <= wr_now;
    end

    // Output enable has no clock; a sampled write overrides it.
    assign rdata_drive = rd_vld && !wr_q && !oe_n;

    assert_float_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        wr_now |=> !rdata_drive);

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              all_we_n,
    input  logic              byte_gate_n,
    input  logic [3:0]        byte_we_n,
    input  logic              burst_mode,
    input  logic              oe_n,
    input  logic [35:0]       wdata,
    output logic [35:0]       rdata,
    output logic              rdata_drive
);

    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_wmask;
    logic              acc_go;
    logic              acc_rd;
    logic              rd_vld;

    bsram_seq #(.AW(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .cs_n       (cs_n),
        .cs_hi      (cs_hi),
        .cs_lo_n    (cs_lo_n),
        .sp_n       (strobe_proc_n),
        .sc_n       (strobe_ctl_n),
        .adv_n      (adv_n),
        .all_n      (all_we_n),
        .gate_n     (byte_gate_n),
        .be_n       (byte_we_n),
        .interleave (burst_mode),
        .acc_addr   (acc_addr),
        .acc_wmask  (acc_wmask),
        .acc_go     (acc_go),
        .acc_rd     (acc_rd)
    );

    bsram_array #(.AW(ADDR_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .acc_addr  (acc_addr),
        .acc_wmask (acc_wmask),
        .acc_rd    (acc_rd),
        .wdata     (wdata),
        .rdata_q   (rdata),
        .rd_vld_q  (rd_vld)
    );

    bsram_drive u_drive (
        .clk         (clk),
        .rst         (rst),
        .wr_now      (|acc_wmask),
        .rd_vld      (rd_vld),
        .oe_n        (oe_n),
        .rdata_drive (rdata_drive)
    );

    // The bus is driven only for a read taken two edges earlier.
    assert_drive_from_read_R9: assert property (@(posedge clk) disable iff (rst)
        rdata_drive |-> $past(acc_rd, 2));

    assert_write_needs_go_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_wmask != '0) |-> acc_go);

endmodule

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          cs_n, cs_hi, cs_lo_n, sp_n, sc_n, adv_n;
    logic          all_we_n, byte_gate_n, burst_mode, oe_n;
    logic [3:0]    byte_we_n;
    logic [35:0]   wdata, rdata;
    logic          rdata_drive;

    always #2.5 clk = ~clk;

    burst_sram_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .cs_hi(cs_hi),
        .cs_lo_n(cs_lo_n), .strobe_proc_n(sp_n), .strobe_ctl_n(sc_n),
        .adv_n(adv_n), .all_we_n(all_we_n), .byte_gate_n(byte_gate_n),
        .byte_we_n(byte_we_n), .burst_mode(burst_mode), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    typedef struct {
        int          due;
        bit          drv;
        logic [35:0] data;
        string       tag;
    } exp_t;

    exp_t          q[$];
    logic [35:0]   ref_mem [64];
    int            edge_cnt = 0;
    int            n_tests  = 0;
    int            n_fail   = 0;
    bit            done     = 0;
    bit            tb_mode  = 0;
    bit            t_live   = 0;
    logic [AW-1:0] t_base   = '0;
    logic [1:0]    t_beat   = '0;

    always @(posedge clk) edge_cnt++;

    // Monitor: compares every expectation that has come due.
    always @(negedge clk) begin
        exp_t e;
        #1;
        while (q.size() > 0 && q[0].due <= edge_cnt) begin
            e = q.pop_front();
            n_tests++;
            if (rdata_drive !== e.drv || (e.drv && rdata !== e.data)) begin
                n_fail++;
                $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h",
                         e.tag, rdata_drive, rdata, e.drv, e.data);
            end
        end
    end

    function automatic logic [35:0] mk(int a, int salt);
        return {9'(a * 3 + salt), 9'(a + 64 + salt), 9'(a ^ salt), 9'(a + salt * 7)};
    endfunction

    // Driver: applies one cycle and queues what is due from it.
    task automatic step(bit c_n, bit c_hi, bit c_lo_n, bit p_n, bit s_n, bit a_n,
                        bit all_n, bit g_n, logic [3:0] be, logic [AW-1:0] a,
                        logic [35:0] d, string tag);
        int            e_edge;
        bit            sel, start, go, forced_rd;
        logic [3:0]    m;
        logic [1:0]    lo;
        logic [AW-1:0] ea;
        exp_t          x;
        @(negedge clk);
        cs_n = c_n; cs_hi = c_hi; cs_lo_n = c_lo_n; sp_n = p_n; sc_n = s_n;
        adv_n = a_n; all_we_n = all_n; byte_gate_n = g_n; byte_we_n = be;
        addr = a; wdata = d; burst_mode = tb_mode;
        e_edge = edge_cnt + 1;
        sel = !c_n && c_hi && !c_lo_n;
        start = 0; go = 0; forced_rd = 0;
        if (!c_n && !p_n) begin
            if (sel) begin start = 1; forced_rd = 1; end
            else t_live = 0;
        end else if (!s_n) begin
            if (sel) start = 1;
            else t_live = 0;
        end else if (t_live) begin
            go = 1;
            if (!a_n) t_beat = t_beat + 2'd1;
        end
        if (start) begin t_base = a; t_beat = 2'd0; t_live = 1; go = 1; end
        m = !all_n ? 4'hF : (!g_n ? ~be : 4'h0);
        if (forced_rd) m = 4'h0;
        lo = tb_mode ? (t_base[1:0] ^ t_beat) : (t_base[1:0] + t_beat);
        ea = {t_base[AW-1:2], lo};
        if (go && m != 4'h0) begin
            for (int l = 0; l < 4; l++)
                if (m[l]) ref_mem[ea][l*9 +: 9] = d[l*9 +: 9];
            if (q.size() > 0 && q[$].due == e_edge) void'(q.pop_back());
            x = '{e_edge, 1'b0, '0, tag};
        end else if (go) begin
            x = '{e_edge + 1, 1'b1, ref_mem[ea], tag};
        end else begin
            x = '{e_edge + 1, 1'b0, '0, tag};
        end
        q.push_back(x);
    endtask

    task automatic bc(logic [AW-1:0] a, bit all_n, bit g_n, logic [3:0] be,
                      logic [35:0] d, string tag);
        step(0, 1, 0, 1, 0, 1, all_n, g_n, be, a, d, tag);
    endtask

    task automatic bp(logic [AW-1:0] a, bit all_n, logic [35:0] d, string tag);
        step(0, 1, 0, 0, 1, 1, all_n, 1, 4'hF, a, d, tag);
    endtask

    task automatic ct(bit a_n, bit all_n, logic [35:0] d, string tag);
        step(1, 1, 0, 1, 1, a_n, all_n, 1, 4'hF, '0, d, tag);
    endtask

    task automatic rd(logic [AW-1:0] a, string tag);
        bc(a, 1, 1, 4'hF, '0, tag);
    endtask

    task automatic dsl(string tag);
        step(1, 1, 0, 1, 0, 1, 1, 1, 4'hF, '0, '0, tag);
    endtask

    task automatic quick(bit ok, string tag, string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; addr = '0; cs_n = 1; cs_hi = 1; cs_lo_n = 0; sp_n = 1; sc_n = 1;
        adv_n = 1; all_we_n = 1; byte_gate_n = 1; byte_we_n = 4'hF;
        burst_mode = 0; oe_n = 0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1 quick(rdata_drive == 1'b0, "R10", $sformatf("reset drive=%0b expected 0", rdata_drive));

        // R3 R7: linear write burst from 0x12 -> 12,13,10,11
        tb_mode = 0;
        bc(6'h12, 0, 1, 4'hF, mk(6'h12, 1), "R7 write begin");
        ct(0, 0, mk(6'h13, 1), "R3 linear write beat1");
        ct(0, 0, mk(6'h10, 1), "R3 linear write beat2");
        ct(0, 0, mk(6'h11, 1), "R3 linear write beat3");
        // R2: interleaved write burst from 0x25 -> 25,24,27,26
        tb_mode = 1;
        bc(6'h25, 0, 1, 4'hF, mk(6'h25, 2), "R7 write begin b");
        ct(0, 0, mk(6'h24, 2), "R2 interleaved write beat1");
        ct(0, 0, mk(6'h27, 2), "R2 interleaved write beat2");
        ct(0, 0, mk(6'h26, 2), "R2 interleaved write beat3");
        // R3 R8 R9: linear read with a suspended beat
        tb_mode = 0;
        rd(6'h11, "R9 read begin 0x11");
        ct(0, 1, '0, "R3 linear read beat1");
        ct(1, 1, '0, "R8 suspend repeats beat");
        ct(0, 1, '0, "R3 linear read beat2");
        ct(0, 1, '0, "R3 linear read wrap");
        // R2 R6: processor-strobe read in interleaved order
        tb_mode = 1;
        bp(6'h26, 1, '0, "R6 proc read begin");
        ct(0, 1, '0, "R2 interleaved read beat1");
        ct(0, 1, '0, "R2 interleaved read beat2");
        ct(0, 1, '0, "R2 interleaved read beat3");
        // R1: partial lane writes and gate behaviour
        tb_mode = 0;
        bc(6'h12, 1, 0, 4'b1010, mk(6'h12, 9), "R1 lanes a,c write");
        bc(6'h13, 1, 1, 4'b0000, mk(6'h13, 9), "R1 gate high is read");
        bc(6'h10, 1, 0, 4'hF, mk(6'h10, 9), "R1 no lane is read");
        rd(6'h12, "R1 merged lanes read");
        // R6: write controls ignored on proc start, write on wait cycle
        bp(6'h24, 0, mk(6'h24, 5), "R6 proc start ignores write");
        ct(1, 0, mk(6'h24, 6), "R6 wait-cycle write");
        rd(6'h24, "R6 readback after wait write");
        // R4: primary enable high
        rd(6'h10, "R4 read begin");
        step(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 6'h3F, '0, "R4 proc strobe ignored");
        step(1, 1, 0, 1, 0, 1, 0, 1, 4'hF, 6'h11, mk(6'h11, 8), "R4 ctl strobe deselect");
        ct(0, 1, '0, "R5 continue after deselect idle");
        rd(6'h11, "R4 deselect wrote nothing");
        // R5: depth-expansion enables inactive
        rd(6'h12, "R5 read begin");
        step(0, 0, 0, 0, 1, 1, 0, 1, 4'hF, 6'h12, mk(6'h12, 4), "R5 proc deselect");
        step(0, 1, 1, 1, 0, 1, 0, 1, 4'hF, 6'h12, mk(6'h12, 3), "R5 ctl deselect");
        ct(1, 1, '0, "R5 hold after deselect idle");
        rd(6'h12, "R5 no write when deselected");
        // R10: asynchronous output enable
        rd(6'h13, "R10 read for oe");
        ct(1, 1, '0, "R10 hold for oe");
        @(negedge clk);
        #1.5 oe_n = 1;
        #0.3 quick(rdata_drive == 1'b0, "R10",
                   $sformatf("oe high drive=%0b expected 0", rdata_drive));
        oe_n = 0;
        #0.3 quick(rdata_drive == 1'b1 && rdata == ref_mem[6'h13], "R10",
                   $sformatf("oe low drive=%0b data=%h expected 1 %h",
                             rdata_drive, rdata, ref_mem[6'h13]));
        dsl("R10 deselect floats");
        dsl("R10 idle floats");
        dsl("R10 drain");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule